// File: doc/BRIEF.md
# Serial Interrupt Line Encoder

This block is the peripheral side of a shared serial interrupt line. Up to six level-sensitive interrupt sources are carried as legacy IRQ numbers over one open-drain wire. The wire is clocked by the PCI clock and shared with a host controller and other agents. The block samples the wire on every clock and waits for a start pulse. It counts three-clock data frames from the clock in which that pulse ends, and it pulls the wire low in the slot of any interrupt that is pending.

The block never drives the wire through a pad. It gives a drive enable and a drive value, and the pad logic outside it builds the open-drain output. The low pulse that closes each cycle (the stop frame) selects the mode for the cycles that follow. In quiet mode the block may open a cycle by itself with a one-clock low pulse when an interrupt level has changed. In continuous mode it waits for the host to start every cycle.

Top module: `sirq_encoder`

## Requirements
- R1: While reset is asserted and just after it, the block does not drive the line (`sirq_oe_o`=0, `sirq_do_o`=0) and is in continuous mode (`quiet_o`=0).
- R2: In idle, a low run on the line of at least 4 clocks that ends with a high clock starts frame counting. A shorter low run in idle is ignored and no slot is ever driven after it.
- R3: Call the first clock in which the line is seen high after the start pulse clock 0. The sample clock of slot n is clock 3n+1, its recovery clock is 3n+2 and its turn-around clock is 3n+3, for slots 0 to 15.
- R4: Source bits map to slots as follows: `irq_i[0]`=slot 3, `irq_i[1]`=slot 4, `irq_i[2]`=slot 5, `irq_i[3]`=slot 9, `irq_i[4]`=slot 10, `irq_i[5]`=slot 11. In a mapped slot's sample clock the block drives low (`sirq_oe_o`=1, `sirq_do_o`=0) exactly when that bit is 1, and otherwise leaves the line released.
- R5: In the recovery clock the block drives high (`sirq_oe_o`=1, `sirq_do_o`=1) only if it drove low in the sample clock just before. In every turn-around clock the line is released.
- R6: Slots with no mapped source are never driven. Low levels that other agents put on the line during those slots have no effect on the block's own slot timing.
- R7: After the turn-around clock of slot 15, the block does not drive the line until a valid stop pulse has been seen.
- R8: After slot 15, a low pulse of exactly 2 clocks selects quiet mode and one of exactly 3 clocks selects continuous mode. Low pulses of any other length are ignored and the block keeps waiting. The new mode shows on `quiet_o` from the clock after the pulse's first high clock.
- R9: In quiet mode, when idle, with the line high for two clocks in a row and some source level different from the level last reported in its slot, the block drives the line low for exactly one clock and then releases it. It does not do this when no level has changed.
- R10: In continuous mode the block never drives the line outside the data frames, whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PCI clock of the serial interrupt line |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Interrupt source levels, 1 = pending, mapped to slots per R4 |
| sirq_i | input | 1 | Sampled level of the shared line |
| sirq_oe_o | output | 1 | Drive enable for the shared line |
| sirq_do_o | output | 1 | Value driven when enabled |
| quiet_o | output | 1 | 1 = quiet mode, 0 = continuous mode |

## Verification
The assertions check on every clock the rules that need no knowledge of slot numbers. A high drive only follows a low drive inside a data frame, and the line is released after every high drive. A self-started pulse lasts one clock, and nothing is driven outside the frames in continuous mode. The bench scenarios cover what depends on counting and on the mapping of sources to slots. These are the position of each slot after start pulses of 4 to 8 clocks, and that short runs in idle and foreign lows in unmapped slots are ignored. They also cover stop pulses of valid and invalid lengths and the condition that a level must change before a quiet-mode start request.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_SRC = 6;
  // slot number of each source bit, in bit order
  localparam int SRC_SLOT [NUM_SRC] = '{3, 4, 5, 9, 10, 11};

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP} seq_st_e;
  typedef enum logic [1:0] {PH_SAMPLE, PH_RECOV, PH_TURN} phase_e;
endpackage

// File: rtl/sirq_line_mon.sv
module sirq_line_mon #(
  parameter int RUN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic [RUN_W-1:0] run_o,
  output logic             rise_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  // length of the current low run, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_o <= '0;
    else if (line_i)           run_o <= '0;
    else if (run_o != RUN_MAX) run_o <= run_o + 1'b1;
  end

  assign rise_o = line_i && (run_o != '0);
endmodule

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int RUN_W      = 4,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic [RUN_W-1:0]  run_i,
  output seq_st_e           state_o,
  output logic [SLOT_W-1:0] slot_o,
  output phase_e            phase_o,
  output logic              quiet_o
);
  localparam logic [RUN_W-1:0]  START_MIN_L = RUN_W'(START_MIN);
  localparam logic [RUN_W-1:0]  STOP_Q_L    = RUN_W'(STOP_QUIET);
  localparam logic [RUN_W-1:0]  STOP_C_L    = RUN_W'(STOP_CONT);
  localparam logic [SLOT_W-1:0] LAST_SLOT   = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      slot_o  <= '0;
      phase_o <= PH_SAMPLE;
      quiet_o <= 1'b0;
    end else begin
      case (state_o)
        ST_IDLE: if (rise_i && run_i >= START_MIN_L) begin
          state_o <= ST_DATA;
          slot_o  <= '0;
          phase_o <= PH_SAMPLE;
        end
        ST_DATA: case (phase_o)
          PH_SAMPLE: phase_o <= PH_RECOV;
          PH_RECOV:  phase_o <= PH_TURN;
          default: begin
            phase_o <= PH_SAMPLE;
            if (slot_o == LAST_SLOT) state_o <= ST_STOP;
            else                     slot_o  <= slot_o + 1'b1;
          end
        endcase
        ST_STOP: if (rise_i) begin
          // other pulse lengths: keep waiting
          if (run_i == STOP_Q_L) begin
            quiet_o <= 1'b1;
            state_o <= ST_IDLE;
          end else if (run_i == STOP_C_L) begin
            quiet_o <= 1'b0;
            state_o <= ST_IDLE;
          end
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sirq_slot_map.sv
module sirq_slot_map
  import sirq_pkg::*;
#(
  parameter int N_SRC  = sirq_pkg::NUM_SRC,
  parameter int SLOT_W = 4
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [N_SRC-1:0]  sel_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    assign sel_o[i] = (slot_i == SLOT_W'(SRC_SLOT[i]));
  end
endmodule

// File: rtl/sirq_encoder.sv
module sirq_encoder
  import sirq_pkg::*;
#(
  parameter int NUM_SRC    = sirq_pkg::NUM_SRC,
  parameter int SLOTS      = 16,
  parameter int RUN_W      = 4,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               sirq_i,
  output logic               sirq_oe_o,
  output logic               sirq_do_o,
  output logic               quiet_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [RUN_W-1:0]   run;
  logic               rise;
  seq_st_e            state;
  logic [SLOT_W-1:0]  slot;
  phase_e             phase;
  logic [NUM_SRC-1:0] sel;
  logic [NUM_SRC-1:0] rep_q;
  logic               in_data, sample, recov, pend_hit;
  logic               drove_q, start_q;

  sirq_line_mon #(.RUN_W(RUN_W)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (sirq_i),
    .run_o  (run),
    .rise_o (rise)
  );

  sirq_frame_seq #(
    .SLOTS(SLOTS), .RUN_W(RUN_W), .START_MIN(START_MIN),
    .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .run_i   (run),
    .state_o (state),
    .slot_o  (slot),
    .phase_o (phase),
    .quiet_o (quiet_o)
  );

  sirq_slot_map #(.N_SRC(NUM_SRC), .SLOT_W(SLOT_W)) u_map (
    .slot_i (slot),
    .sel_o  (sel)
  );

  assign in_data  = (state == ST_DATA);
  assign sample   = in_data && (phase == PH_SAMPLE);
  assign recov    = in_data && (phase == PH_RECOV);
  assign pend_hit = |(sel & irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drove_q <= 1'b0;
      start_q <= 1'b0;
      rep_q   <= '0;
    end else begin
      drove_q <= sample && pend_hit;
      // idle = high on this clock and the one before
      start_q <= (state == ST_IDLE) && quiet_o && !start_q && sirq_i &&
                 (run == '0) && |(irq_i ^ rep_q);
      for (int i = 0; i < NUM_SRC; i++)
        if (sample && sel[i]) rep_q[i] <= irq_i[i];
    end
  end

  assign sirq_oe_o = start_q || (sample && pend_hit) || (recov && drove_q);
  assign sirq_do_o = recov && drove_q;
endmodule

// File: rtl/sirq_enc_chk.sv
module sirq_enc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic oe_i,
  input logic do_i,
  input logic quiet_i,
  input logic in_data_i
);
  AST_RESET_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !oe_i && !do_i && !quiet_i); // R1

  AST_HIGH_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_i |-> oe_i); // R5

  AST_LOW_THEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data_i && oe_i && !do_i |=> oe_i && do_i); // R5

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i && do_i |=> !oe_i); // R5

  AST_START_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_data_i && oe_i |=> !oe_i); // R9

  AST_START_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_data_i && oe_i |-> !do_i && quiet_i); // R9

  AST_CONT_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quiet_i && !in_data_i |-> !oe_i); // R10
endmodule

bind sirq_encoder sirq_enc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_i      (sirq_oe_o),
  .do_i      (sirq_do_o),
  .quiet_i   (quiet_o),
  .in_data_i (in_data)
);

// File: tb/sirq_encoder_tb.sv
module sirq_encoder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] irq = '0;
  logic       host_low = 1'b0;
  logic       other_low = 1'b0;
  logic       sirq_oe, sirq_do, quiet;
  logic       line;

  int   errors = 0;
  int   checks = 0;
  bit   model_quiet = 1'b0;
  logic [5:0] rep = '0;

  assign line = !(host_low || other_low || (sirq_oe && !sirq_do));

  always #4 clk_i = ~clk_i;

  sirq_encoder u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq),
    .sirq_i    (line),
    .sirq_oe_o (sirq_oe),
    .sirq_do_o (sirq_do),
    .quiet_o   (quiet)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
  endtask

  function automatic int idx_of(input int n);
    case (n)
      3: return 0;   4: return 1;   5: return 2;
      9: return 3;   10: return 4;  11: return 5;
      default: return -1;
    endcase
  endfunction

  // one serial cycle: start pulse, 16 slots, optional extra clocks, stop pulse
  task automatic run_cycle(input int len, input bit lead, input logic [5:0] pat,
                           input int bad_len, input int stop_len, input int extra);
    int act, exp, id;
    bit pend;
    if (lead) begin
      nxt();
      chk(sirq_oe && !sirq_do, "R9", "self start drive",
          int'({sirq_oe, sirq_do}), 2);
      host_low = 1'b0;
      for (int k = 0; k < len - 1; k++) begin
        nxt();
        host_low = 1'b1;
      end
    end else begin
      for (int k = 0; k < len; k++) begin
        nxt();
        host_low = 1'b1;
        if (k == 0) irq = pat;
      end
    end
    nxt();
    host_low = 1'b0;
    for (int n = 0; n < 16; n++) begin
      id   = idx_of(n);
      pend = (id >= 0) && pat[id];
      act  = 0;
      exp  = pend ? 6'b101100 : 6'b000000;
      for (int ph = 0; ph < 3; ph++) begin
        nxt();
        act = (act << 2) | int'({sirq_oe, sirq_do});
        other_low = (ph == 0) && (id < 0) && ($urandom_range(0, 2) == 0);
      end
      other_low = 1'b0;
      if (id < 0) chk(act == exp, "R6", $sformatf("unmapped slot %0d", n), act, exp);
      else        chk(act == exp, "R3/R4/R5", $sformatf("slot %0d phases", n), act, exp);
    end
    for (int e = 0; e < extra; e++) begin
      nxt();
      chk(!sirq_oe, "R7", "drive after last slot", int'(sirq_oe), 0);
      other_low = (e == 0) && (extra > 1);
    end
    if (bad_len > 0) begin
      for (int k = 0; k < bad_len; k++) begin
        nxt();
        other_low = 1'b0;
        host_low  = 1'b1;
      end
      nxt();
      host_low = 1'b0;
    end
    for (int k = 0; k < stop_len; k++) begin
      nxt();
      other_low = 1'b0;
      host_low  = 1'b1;
    end
    nxt();
    host_low = 1'b0;
    nxt();
    if (stop_len == 2) model_quiet = 1'b1;
    else if (stop_len == 3) model_quiet = 1'b0;
    chk(quiet == model_quiet, "R8", $sformatf("mode after stop %0d (bad %0d)", stop_len, bad_len),
        int'(quiet), int'(model_quiet));
    rep = pat;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad_seen;
    logic [5:0] pat;
    void'($urandom(32'h5eed_1234));
    repeat (3) nxt();
    chk(!sirq_oe && !sirq_do && !quiet, "R1", "reset state",
        int'({sirq_oe, sirq_do, quiet}), 0);
    rst_ni = 1'b1;
    nxt();
    chk(!sirq_oe && !quiet, "R1", "after reset", int'({sirq_oe, quiet}), 0);

    // short idle low run must not start counting
    for (int k = 0; k < 3; k++) begin
      nxt();
      host_low = 1'b1;
      if (k == 0) irq = 6'h3f;
    end
    nxt();
    host_low = 1'b0;
    bad_seen = 0;
    for (int k = 0; k < 40; k++) begin
      nxt();
      if (sirq_oe) bad_seen++;
    end
    chk(bad_seen == 0, "R2", "drive after 3-clock idle run", bad_seen, 0);

    run_cycle(4, 1'b0, 6'h3f, 0, 3, 0);
    run_cycle(8, 1'b0, 6'b101010, 0, 2, 2);

    // quiet, no level change: no start request
    bad_seen = 0;
    for (int k = 0; k < 5; k++) begin
      nxt();
      if (sirq_oe) bad_seen++;
    end
    chk(bad_seen == 0, "R9", "request without change", bad_seen, 0);

    nxt();
    irq = rep ^ 6'b000001;
    run_cycle(5, 1'b1, rep ^ 6'b000001, 0, 2, 0);

    // invalid stop lengths are ignored
    run_cycle(6, 1'b0, 6'b010101, 5, 3, 1);
    run_cycle(4, 1'b0, 6'b110011, 1, 2, 3);
    run_cycle(7, 1'b0, 6'b000000, 4, 3, 0);

    // continuous: level change must not start a cycle
    nxt();
    irq = 6'h3f;
    bad_seen = 0;
    for (int k = 0; k < 6; k++) begin
      nxt();
      if (sirq_oe) bad_seen++;
    end
    chk(bad_seen == 0, "R10", "start in continuous mode", bad_seen, 0);

    for (int c = 0; c < 60; c++) begin
      pat = 6'($urandom);
      if (model_quiet && ($urandom_range(0, 1) == 1)) begin
        if (pat == rep) pat = pat ^ 6'b100000;
        nxt();
        irq = pat;
        run_cycle($urandom_range(4, 8), 1'b1, pat, 0, $urandom_range(2, 3),
                  $urandom_range(0, 3));
      end else begin
        run_cycle($urandom_range(4, 8), 1'b0, pat,
                  ($urandom_range(0, 4) == 0) ? $urandom_range(4, 6) : 0,
                  $urandom_range(2, 3), $urandom_range(0, 3));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule